// File: doc/BRIEF.md
# Indexed Register Port with Status Flags

This block gives a processor access to a 128-entry byte-wide register file through only two bus addresses. A write to the even address chooses a register. Accesses to the odd address then read or write the chosen register. The file holds the clock's time and alarm bytes, four control and status registers at indices 10 to 13, and free storage. The timekeeping counter and the periodic-rate generator are separate blocks. They read the two control registers from dedicated outputs, and they report events through single-cycle strobes: periodic tick, alarm match, update ended, and the start and end of an update.

The block enforces the special access rules of the control registers. The update-in-progress bit is read-only. Writing the set-mode bit forces the update-ended interrupt enable low. The status register at index 12 is cleared by reading it, and it drives the interrupt output. A power-up reset loads fixed defaults. A separate synchronous bus reset masks the interrupt sources and flags without touching the time data.

Top module: `rtl_regport`

## Requirements
- R1: A write to the even address (sel_data=0) loads the index from wdata[6:0] and ignores wdata[7]. A read from the even address returns 0xFF on rdata in the cycle after rd_stb.
- R2: A read or write to the odd address (sel_data=1) accesses the register at the current index. Read data appears on rdata one cycle after rd_stb and holds until the next read. Storage indices (all except 10 to 13) read back the last value written.
- R3: Index 10 (control A): a write updates bits 6:0 and keeps bit 7, the update-in-progress bit.
- R4: Writes to index 12 (status C) and index 13 (status D) have no effect.
- R5: A write to index 11 (control B) with wdata[7]=1 (set mode) clears control A bit 7 and stores control B with bit 4 (update-ended enable) forced to 0.
- R6: upd_begin sets control A bit 7 only while control B bit 7 is 0. upd_end clears control A bit 7.
- R7: The pf_hit, af_hit and uf_hit strobes set status C bits 0x40, 0x20 and 0x10 respectively. Each also sets bit 0x80 (interrupt flag) when the matching enable in control B (0x40, 0x20, 0x10) is 1. irq equals status C bit 7.
- R8: A read of index 12 returns the status byte and then clears it to 0x00, so irq is low from the next cycle.
- R9: A flag strobe in the same cycle as a status C read takes priority over the clear. The read returns the old value, and the new flag (with the interrupt flag, if enabled) remains set.
- R10: After power-up reset: control A = 0x26, control B = 0x02, status C = 0x00, status D = 0x80, irq = 0, rdata = 0x00, and storage is zero.
- R11: In a bus_rst cycle, control B bits 0x40, 0x20 and 0x08 are cleared and status C is cleared (irq drops). Bus accesses and strobes in that cycle are ignored. Control A, the index and storage keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| bus_rst | input | 1 | Synchronous bus reset: masks enables and clears flags |
| sel_data | input | 1 | Address bit 0: 0 selects the index port, 1 selects the data port |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pf_hit | input | 1 | Periodic event strobe |
| af_hit | input | 1 | Alarm match strobe |
| uf_hit | input | 1 | Update-ended strobe |
| upd_begin | input | 1 | Start of a time update |
| upd_end | input | 1 | End of a time update |
| ctrl_a | output | 8 | Current control A (rate and oscillator fields, update bit) |
| ctrl_b | output | 8 | Current control B (enables and format bits) |
| irq | output | 1 | Interrupt request, status C bit 7 |

## Verification
The bench builds the block with a 7-bit index and storage that is cleared at reset. With these values the whole 128-entry file is reachable, including the top entry 127. An index byte with bit 7 set shows that this bit is dropped. Every storage read has a defined expected value even before the first write. A behavioural model is compared on every clock. The model covers flag strobes that coincide with status reads, set-mode writes racing update strobes, and bus accesses that fall on a bus-reset cycle.

// File: rtl/rtl_regport_pkg.sv
package rtl_regport_pkg;
   localparam int unsigned CTL_A_IX = 10;
   localparam int unsigned CTL_B_IX = 11;
   localparam int unsigned STS_C_IX = 12;
   localparam int unsigned STS_D_IX = 13;

   // control B bit positions
   localparam int unsigned B_SETMODE = 7;
   localparam int unsigned B_PER_EN  = 6;
   localparam int unsigned B_ALM_EN  = 5;
   localparam int unsigned B_UPD_EN  = 4;
   localparam int unsigned B_SQW_EN  = 3;

   // status C bit positions
   localparam int unsigned C_IRQ = 7;
   localparam int unsigned C_PER = 6;
   localparam int unsigned C_ALM = 5;
   localparam int unsigned C_UPD = 4;

   typedef enum logic [2:0] {
      SEL_STORE,
      SEL_CTL_A,
      SEL_CTL_B,
      SEL_STS_C,
      SEL_STS_D
   } reg_sel_e;
endpackage

// File: rtl/rtl_regport_index.sv
module rtl_regport_index #(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] idx_in,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= idx_in;
   end
endmodule

// File: rtl/rtl_regport_store.sv
module rtl_regport_store #(
   parameter int unsigned IDX_W       = 7,
   parameter int unsigned DW          = 8,
   parameter bit          STORE_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] addr,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (STORE_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= din;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= din;
         end
      end
   endgenerate

   assign dout = mem[addr];
endmodule

// File: rtl/rtl_regport_ctrl.sv
module rtl_regport_ctrl
   import rtl_regport_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter logic [7:0]  RST_A = 8'h26,
   parameter logic [7:0]  RST_B = 8'h02,
   parameter logic [7:0]  RST_D = 8'h80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_rst,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic          rd_c,
   input  logic [DW-1:0] wdata,
   input  logic          pf_hit,
   input  logic          af_hit,
   input  logic          uf_hit,
   input  logic          upd_begin,
   input  logic          upd_end,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_c,
   output logic [DW-1:0] reg_d,
   output logic          irq
);
   logic [DW-1:0] a_nxt, b_nxt, c_nxt, c_set;
   logic          set_wr;
   logic [2:0]    src_hit, src_en;

   assign set_wr  = wr_b && wdata[B_SETMODE];
   assign src_hit = {pf_hit, af_hit, uf_hit};
   assign src_en  = {reg_b[B_PER_EN], reg_b[B_ALM_EN], reg_b[B_UPD_EN]};

   always_comb begin
      c_set          = '0;
      c_set[C_PER]   = pf_hit;
      c_set[C_ALM]   = af_hit;
      c_set[C_UPD]   = uf_hit;
      c_set[C_IRQ]   = |(src_hit & src_en);
   end

   always_comb begin
      a_nxt = reg_a;
      if (wr_a) a_nxt[DW-2:0] = wdata[DW-2:0];
      if (set_wr || upd_end)
         a_nxt[DW-1] = 1'b0;
      else if (upd_begin && !reg_b[B_SETMODE])
         a_nxt[DW-1] = 1'b1;

      b_nxt = reg_b;
      if (wr_b) begin
         b_nxt = wdata;
         if (wdata[B_SETMODE]) b_nxt[B_UPD_EN] = 1'b0;
      end

      c_nxt = (rd_c ? '0 : reg_c) | c_set;

      if (bus_rst) begin
         a_nxt = reg_a;
         b_nxt = reg_b;
         b_nxt[B_PER_EN] = 1'b0;
         b_nxt[B_ALM_EN] = 1'b0;
         b_nxt[B_SQW_EN] = 1'b0;
         c_nxt = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= DW'(RST_A);
         reg_b <= DW'(RST_B);
         reg_c <= '0;
      end else begin
         reg_a <= a_nxt;
         reg_b <= b_nxt;
         reg_c <= c_nxt;
      end
   end

   assign reg_d = DW'(RST_D);
   assign irq   = reg_c[C_IRQ];
endmodule

// File: rtl/rtl_regport.sv
module rtl_regport
   import rtl_regport_pkg::*;
#(
   parameter int unsigned IDX_W       = 7,
   parameter int unsigned DW          = 8,
   parameter bit          STORE_CLEAR = 1'b1,
   parameter logic [7:0]  RST_A       = 8'h26,
   parameter logic [7:0]  RST_B       = 8'h02,
   parameter logic [7:0]  RST_D       = 8'h80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_rst,
   input  logic          sel_data,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          pf_hit,
   input  logic          af_hit,
   input  logic          uf_hit,
   input  logic          upd_begin,
   input  logic          upd_end,
   output logic [DW-1:0] ctrl_a,
   output logic [DW-1:0] ctrl_b,
   output logic          irq
);
   generate
      if (DW != 8) begin : g_bad_dw
         $error("rtl_regport: register bit layout needs DW == 8");
      end
      if (IDX_W < 4 || IDX_W > DW - 1) begin : g_bad_idx
         $error("rtl_regport: IDX_W must reach index 13 and fit below the data MSB");
      end
   endgenerate

   logic [IDX_W-1:0] cur_idx;
   reg_sel_e         sel;
   logic             bus_ok, data_wr, data_rd;
   logic [DW-1:0]    store_q, reg_c, reg_d, rd_mux, rdata_q;

   assign bus_ok  = !bus_rst;
   assign data_wr = bus_ok && wr_stb && sel_data;
   assign data_rd = bus_ok && rd_stb && sel_data;

   rtl_regport_index #(.IDX_W(IDX_W)) i_index (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (bus_ok && wr_stb && !sel_data),
      .idx_in (wdata[IDX_W-1:0]),
      .idx_q  (cur_idx)
   );

   always_comb begin
      if (cur_idx == IDX_W'(CTL_A_IX))      sel = SEL_CTL_A;
      else if (cur_idx == IDX_W'(CTL_B_IX)) sel = SEL_CTL_B;
      else if (cur_idx == IDX_W'(STS_C_IX)) sel = SEL_STS_C;
      else if (cur_idx == IDX_W'(STS_D_IX)) sel = SEL_STS_D;
      else                                  sel = SEL_STORE;
   end

   rtl_regport_store #(
      .IDX_W       (IDX_W),
      .DW          (DW),
      .STORE_CLEAR (STORE_CLEAR)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (data_wr && sel == SEL_STORE),
      .addr  (cur_idx),
      .din   (wdata),
      .dout  (store_q)
   );

   rtl_regport_ctrl #(
      .DW    (DW),
      .RST_A (RST_A),
      .RST_B (RST_B),
      .RST_D (RST_D)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .wr_a      (data_wr && sel == SEL_CTL_A),
      .wr_b      (data_wr && sel == SEL_CTL_B),
      .rd_c      (data_rd && sel == SEL_STS_C),
      .wdata     (wdata),
      .pf_hit    (pf_hit),
      .af_hit    (af_hit),
      .uf_hit    (uf_hit),
      .upd_begin (upd_begin),
      .upd_end   (upd_end),
      .reg_a     (ctrl_a),
      .reg_b     (ctrl_b),
      .reg_c     (reg_c),
      .reg_d     (reg_d),
      .irq       (irq)
   );

   always_comb begin
      case (sel)
         SEL_CTL_A: rd_mux = ctrl_a;
         SEL_CTL_B: rd_mux = ctrl_b;
         SEL_STS_C: rd_mux = reg_c;
         SEL_STS_D: rd_mux = reg_d;
         default:   rd_mux = store_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_ok && rd_stb)
         rdata_q <= sel_data ? rd_mux : '1;
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/rtl_regport_chk.sv
module rtl_regport_chk #(
   parameter int unsigned IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rst,
   input logic             sel_data,
   input logic             wr_stb,
   input logic             rd_stb,
   input logic [7:0]       wdata,
   input logic             pf_hit,
   input logic             af_hit,
   input logic             uf_hit,
   input logic             upd_begin,
   input logic             upd_end,
   input logic [7:0]       ctrl_a,
   input logic [7:0]       ctrl_b,
   input logic             irq,
   input logic [IDX_W-1:0] cur_idx
);
   logic rd_sts, wr_a, wr_b;
   assign rd_sts = !bus_rst && rd_stb && sel_data && cur_idx == IDX_W'(12);
   assign wr_a   = !bus_rst && wr_stb && sel_data && cur_idx == IDX_W'(10);
   assign wr_b   = !bus_rst && wr_stb && sel_data && cur_idx == IDX_W'(11);

   // R7
   pf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rst && pf_hit && ctrl_b[6]) |=> irq);

   // R8
   sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sts && !pf_hit && !af_hit && !uf_hit) |=> !irq);

   // R9
   set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sts && af_hit && ctrl_b[5]) |=> irq);

   // R3
   uip_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && !upd_begin && !upd_end) |=>
         (ctrl_a[7] == $past(ctrl_a[7]) && ctrl_a[6:0] == $past(wdata[6:0])));

   // R5
   setmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && wdata[7]) |=> (!ctrl_a[7] && !ctrl_b[4] && ctrl_b[7]));

   // R6
   uip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_b[7] && !ctrl_a[7]) |=> !ctrl_a[7]);

   // R11
   bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> ((ctrl_b & 8'h68) == 8'h00 && !irq));
endmodule

bind rtl_regport rtl_regport_chk #(.IDX_W(IDX_W)) i_regport_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rst   (bus_rst),
   .sel_data  (sel_data),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .wdata     (wdata),
   .pf_hit    (pf_hit),
   .af_hit    (af_hit),
   .uf_hit    (uf_hit),
   .upd_begin (upd_begin),
   .upd_end   (upd_end),
   .ctrl_a    (ctrl_a),
   .ctrl_b    (ctrl_b),
   .irq       (irq),
   .cur_idx   (cur_idx)
);

// File: tb/test_rtl_regport.sv
module test_rtl_regport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0, sel_data = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0] wdata = '0;
   logic       pf_hit = 1'b0, af_hit = 1'b0, uf_hit = 1'b0;
   logic       upd_begin = 1'b0, upd_end = 1'b0;
   logic [7:0] rdata, ctrl_a, ctrl_b;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   rtl_regport i_rtl_regport (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .sel_data(sel_data),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata),
      .pf_hit(pf_hit), .af_hit(af_hit), .uf_hit(uf_hit),
      .upd_begin(upd_begin), .upd_end(upd_end),
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq)
   );

   // reference model state
   int         m_idx;
   logic [7:0] m_a, m_b, m_c, m_rd;
   logic [7:0] m_mem [128];

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input int ix);
      case (ix)
         10: return m_a;
         11: return m_b;
         12: return m_c;
         13: return 8'h80;
         default: return m_mem[ix];
      endcase
   endfunction

   // one clock: model follows the applied inputs, then outputs are compared
   task automatic tick(input string tag);
      logic [7:0] na, nb, nc;
      int nidx;
      @(posedge clk);
      na = m_a; nb = m_b; nc = m_c; nidx = m_idx;
      if (bus_rst) begin
         nb = m_b & 8'h97;
         nc = 8'h00;
      end else begin
         if (rd_stb) m_rd = sel_data ? m_read(m_idx) : 8'hFF;
         if (wr_stb && !sel_data) nidx = int'(wdata & 8'h7F);
         if (wr_stb && sel_data) begin
            if (m_idx == 10) na = {m_a[7], wdata[6:0]};
            else if (m_idx == 11) nb = wdata[7] ? (wdata & 8'hEF) : wdata;
            else if (m_idx != 12 && m_idx != 13) m_mem[m_idx] = wdata;
         end
         if (wr_stb && sel_data && m_idx == 11 && wdata[7]) na[7] = 1'b0;
         else if (upd_end) na[7] = 1'b0;
         else if (upd_begin && !m_b[7]) na[7] = 1'b1;
         if (rd_stb && sel_data && m_idx == 12) nc = 8'h00;
         if (pf_hit) nc = nc | 8'h40 | (m_b[6] ? 8'h80 : 8'h00);
         if (af_hit) nc = nc | 8'h20 | (m_b[5] ? 8'h80 : 8'h00);
         if (uf_hit) nc = nc | 8'h10 | (m_b[4] ? 8'h80 : 8'h00);
      end
      m_a = na; m_b = nb; m_c = nc; m_idx = nidx;
      @(negedge clk);
      chk(rdata, m_rd, {tag, " rdata"});
      chk(ctrl_a, m_a, {tag, " ctrl_a"});
      chk(ctrl_b, m_b, {tag, " ctrl_b"});
      chk({7'd0, irq}, {7'd0, m_c[7]}, {tag, " irq"});
      bus_rst = 0; wr_stb = 0; rd_stb = 0; sel_data = 0;
      pf_hit = 0; af_hit = 0; uf_hit = 0; upd_begin = 0; upd_end = 0;
   endtask

   task automatic do_wr(input logic a0, input logic [7:0] d, input string tag);
      sel_data = a0; wr_stb = 1; wdata = d;
      tick(tag);
   endtask

   task automatic do_rd(input logic a0, input string tag);
      sel_data = a0; rd_stb = 1;
      tick(tag);
   endtask

   task automatic rd_reg(input int ix, input logic [7:0] exp, input string tag);
      do_wr(1'b0, 8'(ix), tag);
      do_rd(1'b1, tag);
      chk(rdata, exp, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      m_idx = 0; m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_rd = 8'h00;
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk(ctrl_a, 8'h26, "R10 ctrl_a");
      chk(ctrl_b, 8'h02, "R10 ctrl_b");
      chk({7'd0, irq}, 8'h00, "R10 irq");
      chk(rdata, 8'h00, "R10 rdata");
      rd_reg(13, 8'h80, "R10 status D");
      rd_reg(12, 8'h00, "R10 status C");
      rd_reg(40, 8'h00, "R10 storage");

      // R1 index load drops bit 7, even read gives FF
      do_wr(1'b0, 8'h8F, "R1 index");
      do_wr(1'b1, 8'h5A, "R1 data");
      do_rd(1'b1, "R1 readback");
      chk(rdata, 8'h5A, "R1 index bit7 dropped");
      do_rd(1'b0, "R1 even read");
      chk(rdata, 8'hFF, "R1 even read FF");

      // R2 storage at both ends of the file
      do_wr(1'b0, 8'd127, "R2 idx");
      do_wr(1'b1, 8'hC3, "R2 wr127");
      do_wr(1'b0, 8'd0, "R2 idx");
      do_wr(1'b1, 8'h11, "R2 wr0");
      rd_reg(127, 8'hC3, "R2 top entry");
      rd_reg(0, 8'h11, "R2 bottom entry");

      // R3 update bit read-only
      upd_begin = 1; tick("R6 begin");
      chk(ctrl_a, 8'hA6, "R6 update bit set");
      do_wr(1'b0, 8'd10, "R3 idx");
      do_wr(1'b1, 8'h00, "R3 wr A");
      chk(ctrl_a, 8'h80, "R3 bit7 kept");
      do_wr(1'b1, 8'h7F, "R3 wr A");
      chk(ctrl_a, 8'hFF, "R3 low bits written");
      upd_end = 1; tick("R6 end");
      chk(ctrl_a, 8'h7F, "R6 update bit cleared");
      do_wr(1'b1, 8'h26, "R3 restore");

      // R4 C and D ignore writes
      do_wr(1'b0, 8'd12, "R4 idx");
      do_wr(1'b1, 8'hFF, "R4 wr C");
      do_rd(1'b1, "R4 rd C");
      chk(rdata, 8'h00, "R4 status C unchanged");
      chk({7'd0, irq}, 8'h00, "R4 irq unchanged");
      do_wr(1'b0, 8'd13, "R4 idx");
      do_wr(1'b1, 8'h00, "R4 wr D");
      do_rd(1'b1, "R4 rd D");
      chk(rdata, 8'h80, "R4 status D unchanged");

      // R7 flags without and with enables
      pf_hit = 1; tick("R7 pf no enable");
      chk({7'd0, irq}, 8'h00, "R7 no irq when disabled");
      rd_reg(12, 8'h40, "R7 pf flag only");
      do_wr(1'b0, 8'd11, "R7 idx");
      do_wr(1'b1, 8'h72, "R7 enables");
      pf_hit = 1; tick("R7 pf enabled");
      chk({7'd0, irq}, 8'h01, "R7 irq raised");
      uf_hit = 1; tick("R7 uf enabled");
      do_wr(1'b0, 8'd12, "R8 idx");
      do_rd(1'b1, "R8 read C");
      chk(rdata, 8'hD0, "R8 returned flags");
      chk({7'd0, irq}, 8'h00, "R8 irq dropped");
      do_rd(1'b1, "R8 read again");
      chk(rdata, 8'h00, "R8 cleared");

      // R9 set racing a status read
      af_hit = 1; tick("R9 first alarm");
      sel_data = 1; rd_stb = 1; af_hit = 1; tick("R9 read with alarm");
      chk(rdata, 8'hA0, "R9 old value returned");
      chk({7'd0, irq}, 8'h01, "R9 irq kept");
      do_rd(1'b1, "R9 reread");
      chk(rdata, 8'hA0, "R9 flag survived");

      // R5 / R6 set mode
      upd_begin = 1; tick("R5 begin");
      do_wr(1'b0, 8'd11, "R5 idx");
      do_wr(1'b1, 8'h92, "R5 set mode");
      chk(ctrl_b, 8'h82, "R5 enable forced low");
      chk(ctrl_a, 8'h26, "R5 update bit cleared");
      upd_begin = 1; tick("R6 begin in set mode");
      chk(ctrl_a, 8'h26, "R6 begin ignored in set mode");
      do_wr(1'b1, 8'h02, "R6 leave set mode");
      upd_begin = 1; tick("R6 begin normal");
      chk(ctrl_a, 8'hA6, "R6 begin accepted");
      upd_end = 1; tick("R6 end");

      // R11 bus reset
      do_wr(1'b1, 8'h7A, "R11 enables");
      pf_hit = 1; tick("R11 pf");
      chk({7'd0, irq}, 8'h01, "R11 irq before");
      bus_rst = 1; sel_data = 0; wr_stb = 1; wdata = 8'd5; pf_hit = 1;
      tick("R11 bus reset");
      chk(ctrl_b, 8'h12, "R11 enables masked");
      chk({7'd0, irq}, 8'h00, "R11 irq cleared");
      do_rd(1'b1, "R11 index kept");
      chk(rdata, 8'h12, "R11 index kept");
      rd_reg(12, 8'h00, "R11 flags cleared");
      rd_reg(127, 8'hC3, "R11 storage kept");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule